// File: doc/BRIEF.md
# Address-Striped Pseudo-Channel Dispatcher

This block takes burst-sized memory requests over a valid/ready interface. It sends each burst to one of a power-of-two number of independent pseudo-channels. The channel is chosen from the address bits just above the burst offset. Same-address traffic therefore always lands on the same channel and queues there, while traffic to different channels is served side by side.

A transaction is one or more bursts sent back to back, with the last one flagged. Only the first burst's address and id are used. Later bursts step through the address space one burst size at a time, so a long transaction spreads across neighbouring channels. Each channel keeps a busy down-counter and the direction of its last access. When the direction flips, a turnaround charge is added. Each transaction waits in a small table until the latest of its bursts has finished. Its completion is then offered on a separate valid/ready response port. New requests are still accepted while earlier transactions drain.

Burst size and channel count must both be powers of two. Any other value stops elaboration with an error.

Top module: `stripeDispatch`

## Requirements
- R1: The channel of a burst is `(burstAddress >> log2(BURST_BYTES)) & (NUM_CH-1)`. With 256-byte bursts and 8 channels, this is bit field [10:8]. `issueOnehot` shows that channel as a single set bit in the same cycle as the burst is accepted, and it is all zero in any cycle with no acceptance.
- R2: The first burst of a transaction (no transaction open) uses `reqAddr` and `reqId`. Burst k of the transaction uses first address + k*BURST_BYTES. On the later bursts, `reqAddr` and `reqId` are ignored.
- R3: Each channel holds a remaining-busy count b that drops by one per cycle, stopping at zero. A burst accepted onto the channel sets the count to max(b-1,0) + penalty + CHUNK_CYCLES. Same-channel bursts therefore queue behind each other, and counts on other channels are not affected.
- R4: The penalty is SWITCH_CYCLES when the channel's last access had the opposite direction (`reqWrite`: 1 = write, 0 = read). Otherwise the penalty is 0. After reset no channel has a recorded direction, so its first access pays no penalty.
- R5: A transaction's count is the maximum of its bursts' finish counts, and it also drops by one per cycle. Once the last burst has been accepted and the count is zero, `respValid` is asserted with that transaction's first-burst id on `respId`.
- R6: `reqReady` is high only when two conditions hold. First, a transaction is open or a table slot (MAX_TXN slots) is free. Second, the target channel's count is no more than 2^BUSY_W-1-CHUNK_CYCLES-SWITCH_CYCLES.
- R7: After reset, `reqReady` is 1, `respValid` is 0 and `issueOnehot` is 0.
- R8: When several transactions are complete at once, the lowest table slot is offered first. A new transaction takes the lowest free slot. An offered response keeps the same id until `respReady` takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Burst request valid |
| reqReady | output | 1 | Burst request accepted when high with reqValid |
| reqAddr | input | ADDR_W | Byte address (used on first burst only) |
| reqId | input | ID_W | Transaction id (used on first burst only) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLast | input | 1 | Marks the final burst of the transaction |
| respValid | output | 1 | Completion available |
| respReady | input | 1 | Completion taken |
| respId | output | ID_W | Id of the completed transaction |
| issueOnehot | output | NUM_CH | Channel receiving the burst accepted this cycle |

## Verification
The bench builds the block with 8 channels of 256 bytes, a 4-cycle service time and a 3-cycle turnaround, which keeps the mapping on bits [10:8] observable. It uses a 4-entry table, so blocking responses fills the table within a few requests. The busy counter is only 4 bits wide, which puts the headroom limit at 8 cycles. Alternating read/write traffic to one address then drives the channel against that limit and holds `reqReady` low for address reasons alone.

// File: rtl/stripePkg.sv
package stripePkg;
  // Strobes handed from the transaction control to the channel datapath.
  typedef struct packed {
    logic accept;    // a burst is taken this cycle
    logic writeDir;  // direction of that burst
  } dispStrobe_t;
endpackage

// File: rtl/stripeChanPath.sv
module stripeChanPath
  import stripePkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int BURST_BYTES   = 256,
  parameter int NUM_CH        = 8,
  parameter int CHUNK_CYCLES  = 4,
  parameter int SWITCH_CYCLES = 2,
  parameter int BUSY_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dispStrobe_t       strb,
  input  logic              firstBurst,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [NUM_CH-1:0] issueOnehot,
  output logic              chanOk,
  output logic [BUSY_W-1:0] newBusy
);
  localparam int SHIFT    = $clog2(BURST_BYTES);
  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int HEADROOM = (1 << BUSY_W) - 1 - CHUNK_CYCLES - SWITCH_CYCLES;

  logic [ADDR_W-1:0] nextAddrQ;
  logic [ADDR_W-1:0] burstAddr;
  logic [CH_W-1:0]   chIdx;
  logic [BUSY_W-1:0] busyQ   [NUM_CH];
  logic [NUM_CH-1:0] lastWrQ;
  logic [NUM_CH-1:0] lastVldQ;
  logic [BUSY_W-1:0] tgtBusy;
  logic [BUSY_W-1:0] tgtDec;
  logic              turnPen;

  assign burstAddr = firstBurst ? reqAddr : nextAddrQ;

  generate
    if (NUM_CH > 1) begin : g_chSel
      assign chIdx = burstAddr[SHIFT +: CH_W];
    end else begin : g_chOne
      assign chIdx = '0;
    end
  endgenerate

  assign tgtBusy = busyQ[chIdx];
  assign tgtDec  = (tgtBusy != '0) ? tgtBusy - 1'b1 : '0;
  assign turnPen = lastVldQ[chIdx] && (lastWrQ[chIdx] != strb.writeDir);
  assign newBusy = tgtDec + (turnPen ? BUSY_W'(SWITCH_CYCLES) : '0) + BUSY_W'(CHUNK_CYCLES);
  assign chanOk  = (int'(tgtBusy) <= HEADROOM);

  always_ff @(posedge clk) begin
    if (!rstN) nextAddrQ <= '0;
    else if (strb.accept) nextAddrQ <= burstAddr + ADDR_W'(BURST_BYTES);
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      logic hit;
      assign hit            = strb.accept && (chIdx == CH_W'(c));
      assign issueOnehot[c] = hit;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          busyQ[c]    <= '0;
          lastWrQ[c]  <= 1'b0;
          lastVldQ[c] <= 1'b0;
        end else if (hit) begin
          busyQ[c]    <= newBusy;
          lastWrQ[c]  <= strb.writeDir;
          lastVldQ[c] <= 1'b1;
        end else if (busyQ[c] != '0) begin
          busyQ[c] <= busyQ[c] - 1'b1;
        end
      end
    end
  endgenerate

  // R1: at most one channel is issued per cycle
  assert_issue_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueOnehot));

  // R3: a loaded channel is busy for at least one service time
  assert_busy_loaded_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.accept |=> int'(busyQ[$past(chIdx)]) >= CHUNK_CYCLES);

  // R4: an untouched idle channel pays no turnaround
  assert_first_no_penalty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !lastVldQ[chIdx] && tgtBusy == '0)
      |=> int'(busyQ[$past(chIdx)]) == CHUNK_CYCLES);
endmodule

// File: rtl/stripeTxnTable.sv
module stripeTxnTable
  import stripePkg::*;
#(
  parameter int ID_W    = 4,
  parameter int MAX_TXN = 4,
  parameter int BUSY_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqLast,
  input  logic [ID_W-1:0]   reqId,
  input  logic              chanOk,
  input  logic [BUSY_W-1:0] newBusy,
  output logic              reqReady,
  output dispStrobe_t       strb,
  output logic              firstBurst,
  output logic              respValid,
  input  logic              respReady,
  output logic [ID_W-1:0]   respId
);
  localparam int SLOT_W = (MAX_TXN > 1) ? $clog2(MAX_TXN) : 1;

  logic [MAX_TXN-1:0] entV, entClosed;
  logic [ID_W-1:0]    entId  [MAX_TXN];
  logic [BUSY_W-1:0]  entRem [MAX_TXN];
  logic               openV, holdV;
  logic [SLOT_W-1:0]  openSlot, holdSlot;
  logic               freeAvail, anyDone;
  logic [SLOT_W-1:0]  freeSlot, doneSlot, sel, tgtSlot;
  logic               accept, respFire;

  always_comb begin
    freeAvail = 1'b0;
    freeSlot  = '0;
    anyDone   = 1'b0;
    doneSlot  = '0;
    for (int i = MAX_TXN - 1; i >= 0; i--) begin
      if (!entV[i]) begin
        freeAvail = 1'b1;
        freeSlot  = SLOT_W'(i);
      end
      if (entV[i] && entClosed[i] && entRem[i] == '0) begin
        anyDone  = 1'b1;
        doneSlot = SLOT_W'(i);
      end
    end
  end

  assign sel        = holdV ? holdSlot : doneSlot;
  assign respValid  = holdV || anyDone;
  assign respId     = entId[sel];
  assign respFire   = respValid && respReady;
  assign firstBurst = !openV;
  assign reqReady   = (openV || freeAvail) && chanOk;
  assign accept     = reqValid && reqReady;
  assign tgtSlot    = openV ? openSlot : freeSlot;
  assign strb       = '{accept: accept, writeDir: reqWrite};

  generate
    for (genvar s = 0; s < MAX_TXN; s++) begin : g_slot
      logic [BUSY_W-1:0] remDec;
      assign remDec = (entRem[s] != '0) ? entRem[s] - 1'b1 : '0;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entV[s]      <= 1'b0;
          entClosed[s] <= 1'b0;
          entId[s]     <= '0;
          entRem[s]    <= '0;
        end else if (respFire && sel == SLOT_W'(s)) begin
          entV[s] <= 1'b0;
        end else if (accept && tgtSlot == SLOT_W'(s)) begin
          entClosed[s] <= reqLast;
          if (!openV) begin
            entV[s]   <= 1'b1;
            entId[s]  <= reqId;
            entRem[s] <= newBusy;
          end else begin
            entRem[s] <= (newBusy > remDec) ? newBusy : remDec;
          end
        end else begin
          entRem[s] <= remDec;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openV    <= 1'b0;
      openSlot <= '0;
      holdV    <= 1'b0;
      holdSlot <= '0;
    end else begin
      if (accept) begin
        openV    <= !reqLast;
        openSlot <= tgtSlot;
      end
      holdV    <= respValid && !respReady;
      holdSlot <= sel;
    end
  end

  // R8: a response that is offered stays stable until taken
  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> (respValid && respId == $past(respId)));

  // R5: a transaction still accepting bursts is never reported done
  assert_resp_after_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !(openV && openSlot == sel));
endmodule

// File: rtl/stripeDispatch.sv
module stripeDispatch
  import stripePkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int ID_W          = 4,
  parameter int BURST_BYTES   = 256,
  parameter int NUM_CH        = 8,
  parameter int CHUNK_CYCLES  = 4,
  parameter int SWITCH_CYCLES = 2,
  parameter int BUSY_W        = 8,
  parameter int MAX_TXN       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqWrite,
  input  logic              reqLast,
  output logic              respValid,
  input  logic              respReady,
  output logic [ID_W-1:0]   respId,
  output logic [NUM_CH-1:0] issueOnehot
);
  generate
    if (BURST_BYTES <= 0 || (BURST_BYTES & (BURST_BYTES - 1)) != 0) begin : g_badBurst
      $error("stripeDispatch: BURST_BYTES has to be a positive power of two");
    end
    if (NUM_CH <= 0 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_badChan
      $error("stripeDispatch: NUM_CH has to be a positive power of two");
    end
    if ((1 << BUSY_W) - 1 - CHUNK_CYCLES - SWITCH_CYCLES < 0) begin : g_badBusy
      $error("stripeDispatch: BUSY_W too narrow for one service time");
    end
  endgenerate

  dispStrobe_t       strb;
  logic              firstBurst;
  logic              chanOk;
  logic [BUSY_W-1:0] newBusy;

  stripeTxnTable #(
    .ID_W(ID_W), .MAX_TXN(MAX_TXN), .BUSY_W(BUSY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLast(reqLast), .reqId(reqId),
    .chanOk(chanOk), .newBusy(newBusy),
    .reqReady(reqReady), .strb(strb), .firstBurst(firstBurst),
    .respValid(respValid), .respReady(respReady), .respId(respId)
  );

  stripeChanPath #(
    .ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES), .NUM_CH(NUM_CH),
    .CHUNK_CYCLES(CHUNK_CYCLES), .SWITCH_CYCLES(SWITCH_CYCLES), .BUSY_W(BUSY_W)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .strb(strb), .firstBurst(firstBurst), .reqAddr(reqAddr),
    .issueOnehot(issueOnehot), .chanOk(chanOk), .newBusy(newBusy)
  );
endmodule

// File: tb/sim_stripeDispatch.sv
module sim_stripeDispatch;
  localparam int ADDR_W = 32, ID_W = 4, BURST = 256, NCH = 8;
  localparam int CHUNK = 4, SW = 3, BUSY_W = 4, MAXT = 4;
  localparam int SHIFT = 8;
  localparam int HEAD = (1 << BUSY_W) - 1 - CHUNK - SW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, reqValid = 1'b0, reqWrite = 1'b0, reqLast = 1'b0, respReady = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [ID_W-1:0]   reqId = '0;
  logic reqReady, respValid;
  logic [ID_W-1:0] respId;
  logic [NCH-1:0] issueOnehot;

  stripeDispatch #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .BURST_BYTES(BURST), .NUM_CH(NCH),
    .CHUNK_CYCLES(CHUNK), .SWITCH_CYCLES(SW), .BUSY_W(BUSY_W), .MAX_TXN(MAXT)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqId(reqId), .reqWrite(reqWrite), .reqLast(reqLast),
    .respValid(respValid), .respReady(respReady), .respId(respId),
    .issueOnehot(issueOnehot)
  );

  // Behavioural reference state
  int busy[NCH];
  bit lastV[NCH], lastW[NCH];
  bit eV[MAXT], eC[MAXT];
  int eId[MAXT], eRem[MAXT];
  bit openV = 0, holdV = 0;
  int openSlot = 0, holdSlot = 0;
  int unsigned nextAddr = 0;
  int nCmp = 0, nBad = 0, cycles = 0;
  bit randResp = 0;

  initial begin
    for (int i = 0; i < NCH; i++) begin busy[i] = 0; lastV[i] = 0; lastW[i] = 0; end
    for (int i = 0; i < MAXT; i++) begin eV[i] = 0; eC[i] = 0; eId[i] = 0; eRem[i] = 0; end
  end

  function automatic int curAddr();
    return openV ? int'(nextAddr) : int'(reqAddr);
  endfunction
  function automatic int expCh();
    return (int'(curAddr()) >>> SHIFT) & (NCH - 1);
  endfunction
  function automatic int expFree();
    for (int i = 0; i < MAXT; i++) if (!eV[i]) return i;
    return -1;
  endfunction
  function automatic int expSel();
    if (holdV) return holdSlot;
    for (int i = 0; i < MAXT; i++) if (eV[i] && eC[i] && eRem[i] == 0) return i;
    return -1;
  endfunction
  function automatic bit expReady();
    return (openV || expFree() >= 0) && busy[expCh()] <= HEAD;
  endfunction

  task automatic check(string tag, bit ok, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  task automatic compare();
    int sel, expIss;
    sel = expSel();
    check("R6 reqReady", reqReady === expReady(), int'(reqReady), int'(expReady()));
    check("R5 respValid", respValid === (sel >= 0), int'(respValid), int'(sel >= 0));
    if (sel >= 0)
      check("R8 respId", respId === ID_W'(eId[sel]), int'(respId), eId[sel]);
    expIss = (reqValid && expReady()) ? (1 << expCh()) : 0;
    if (openV)
      check("R2 striped issue", issueOnehot === NCH'(expIss), int'(issueOnehot), expIss);
    else
      check("R1 issue channel", issueOnehot === NCH'(expIss), int'(issueOnehot), expIss);
  endtask

  // Model advance on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      for (int i = 0; i < NCH; i++) begin busy[i] = 0; lastV[i] = 0; lastW[i] = 0; end
      for (int i = 0; i < MAXT; i++) begin eV[i] = 0; eC[i] = 0; eRem[i] = 0; end
      openV = 0; holdV = 0; openSlot = 0; holdSlot = 0; nextAddr = 0;
    end else begin
      bit acc, rsp;
      int sel, c, tgt, newB, pen, addrUse;
      acc = reqValid && expReady();
      sel = expSel();
      rsp = (sel >= 0) && respReady;
      c = expCh();
      addrUse = curAddr();
      tgt = openV ? openSlot : expFree();
      pen = (lastV[c] && lastW[c] != reqWrite) ? SW : 0;
      newB = ((busy[c] > 0) ? busy[c] - 1 : 0) + pen + CHUNK;
      for (int i = 0; i < NCH; i++) begin
        if (acc && i == c) begin busy[i] = newB; lastV[i] = 1; lastW[i] = reqWrite; end
        else if (busy[i] > 0) busy[i]--;
      end
      for (int i = 0; i < MAXT; i++) begin
        if (rsp && sel == i) eV[i] = 0;
        else if (acc && tgt == i) begin
          eC[i] = reqLast;
          if (!openV) begin eV[i] = 1; eId[i] = int'(reqId); eRem[i] = newB; end
          else begin
            if (eRem[i] > 0) eRem[i]--;
            if (newB > eRem[i]) eRem[i] = newB;
          end
        end else if (eRem[i] > 0) eRem[i]--;
      end
      holdV = (sel >= 0) && !respReady;
      holdSlot = (sel >= 0) ? sel : 0;
      if (acc) begin
        openV = !reqLast; openSlot = tgt;
        nextAddr = int'(addrUse) + BURST;
      end
    end
  end

  task automatic tick();
    if (randResp) respReady = ($urandom_range(0, 1) == 1);
    #2 compare();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(int unsigned a, int id, bit wr, bit last);
    bit took;
    reqValid = 1; reqAddr = a; reqId = ID_W'(id); reqWrite = wr; reqLast = last;
    do begin
      took = expReady();
      tick();
    end while (!took);
    reqValid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    @(negedge clk);
    idle(3);
    rstN = 1;
    // R7: reset state
    #1 check("R7 reset ready", reqReady === 1'b1, int'(reqReady), 1);
    check("R7 reset resp", respValid === 1'b0, int'(respValid), 0);
    check("R7 reset issue", issueOnehot === '0, int'(issueOnehot), 0);
    @(negedge clk);
    respReady = 1;
    // R1: bits [10:8] choose the channel; bit 12 has no role
    send(32'h0000_0300, 1, 0, 1);
    send(32'h0000_0700, 2, 0, 1);
    send(32'h0000_1500, 3, 0, 1);
    idle(12);
    // R3: same address serializes on one channel
    send(32'h0000_0200, 4, 1, 1);
    send(32'h0000_0210, 5, 1, 1);
    idle(14);
    // R4: direction flip on one channel pays the turnaround
    send(32'h0000_0400, 6, 0, 1);
    send(32'h0000_0400, 7, 1, 1);
    idle(16);
    // R2: later bursts ignore reqAddr and reqId
    send(32'h0000_0600, 8, 1, 0);
    send(32'hDEAD_0000, 15, 1, 0);
    send(32'hBEEF_0000, 14, 0, 0);
    send(32'h0000_0000, 13, 0, 1);
    idle(14);
    // R6 and R8: fill the table with responses blocked
    respReady = 0;
    for (int k = 0; k < MAXT; k++) send(32'h0000_0100 * k, 9 + k, 0, 1);
    idle(10);
    reqValid = 1; reqAddr = 32'h0000_0500; reqId = 4'd2; reqWrite = 0; reqLast = 1;
    idle(4);
    respReady = 1;
    begin
      bit took;
      do begin took = expReady(); tick(); end while (!took);
    end
    reqValid = 0;
    idle(12);
    // R6: alternating directions to one address push against the headroom
    for (int k = 0; k < 10; k++) send(32'h0000_0100, k, k[0], 1);
    idle(40);
    // Mixed traffic with random response backpressure
    randResp = 1;
    for (int t = 0; t < 600; t++) begin
      int nb;
      int unsigned a;
      nb = $urandom_range(1, 4);
      a = $urandom & 32'h0000_0F00;
      for (int b = 0; b < nb; b++)
        send(a, t & 15, ($urandom_range(0, 1) == 1), b == nb - 1);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 6));
    end
    randResp = 0;
    respReady = 1;
    idle(80);
    // R5: everything drained
    #1 check("R5 drained", respValid === 1'b0, int'(respValid), 0);
    check("R6 ready after drain", reqReady === 1'b1, int'(reqReady), 1);
    finishRun();
  end
endmodule